// File: doc/BRIEF.md
# Byte-Coded Tightly Coupled Memory with Stall-and-Repair

This block wraps a small, word-wide local memory that sits close to a processor. Each byte of every word is kept as its own 12-bit Hamming codeword. Reads check every byte of the addressed word. A clean word comes back on the cycle after the request is accepted.

When one or more bytes hold a correctable single-bit fault, the requester is held for exactly one extra cycle. The corrected data is then returned, and the repaired codewords are written back into the array so that later reads are clean. The repair stays inside the memory wrapper, so processor timing such as interrupt latency has a fixed upper bound.

A fault that cannot be repaired ends the read with an abort instead of data. Instruction-side reads raise a prefetch abort at once. Data-side reads hold the requester for a parameterised number of cycles and then raise a data abort. The first reported fault is kept in an address register and a status register until a clear pulse arrives. An injection mask on the write path lets a test corrupt stored codewords on purpose.

Top module: `tcm_ecc`

## Requirements
- R1: A read accepted at a clock edge with no stored fault returns the written word with rspValid high in the very next cycle. No abort is raised. reqReady is high again in the following cycle.
- R2: Each byte is a 12-bit codeword: check bits at positions 1, 2, 4 and 8, and data bits d0..d7 at positions 3, 5, 6, 7, 9, 10, 11 and 12. Position p is stored in bit p-1. If any byte's syndrome is in 1..12 and no byte is uncorrectable, the cycle after acceptance is a stall with rspValid low. The next cycle carries rspValid with the fully corrected word.
- R3: After a correction, the repaired codewords are written back in the stall cycle. A second read of that address is clean and takes one cycle.
- R4: A syndrome of 13, 14 or 15 in any byte makes the read uncorrectable. For an instruction-side read (reqFetch=1), prefetchAbort pulses in the cycle after acceptance with rspValid low, and reqReady returns the next cycle.
- R5: For an uncorrectable data-side read, reqReady stays low for the check cycle and for ABORT_STALL further cycles. dataAbort then pulses for one cycle, still with reqReady low, and reqReady is high the cycle after.
- R6: A write recomputes and stores codewords only for bytes whose reqBe bit is set. Other bytes keep their data and their check bits, including any stored fault.
- R7: On a corrected or uncorrectable read, if faultStatus is zero, faultAddr takes the word address and faultStatus takes {side, cause}. Side is 1 for instruction side. Cause is 2'b01 for corrected and 2'b10 for uncorrectable. Otherwise both registers keep the first fault.
- R8: A faultClear pulse sets faultStatus and faultAddr to zero on the next edge.
- R9: On a write, injMask is XORed into the codeword of each enabled byte (12 bits per byte, byte 0 lowest) before it is stored.
- R10: After reset, reqReady is 1, rspValid, prefetchAbort and dataAbort are 0, and faultStatus is 0.
- R11: A write is accepted in the cycle where reqValid and reqReady are both high and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqFetch | input | 1 | 1 = instruction-side access |
| reqAddr | input | ADDR_W | Word address |
| reqBe | input | BYTES | Byte write enables |
| reqWdata | input | 8*BYTES | Write data |
| injMask | input | 12*BYTES | Codeword corruption mask applied on writes |
| rspValid | output | 1 | Read data valid |
| rspRdata | output | 8*BYTES | Read data (corrected) |
| prefetchAbort | output | 1 | Uncorrectable instruction-side read |
| dataAbort | output | 1 | Uncorrectable data-side read |
| faultClear | input | 1 | Clears the fault registers |
| faultAddr | output | ADDR_W | Address of the first recorded fault |
| faultStatus | output | 3 | {side, cause} of the first recorded fault |

## Verification
If a read is accepted at edge T, a clean word is due in cycle T+1. A corrected word is due in T+2. A prefetch abort is due in T+1, and a data abort in T+2+ABORT_STALL. Fault registers change at the end of cycle T+1. The bench drives on falling edges and builds, for each read, a per-cycle list of expected ready, response and abort values from the stored error masks. It samples on every falling edge from acceptance until the port is idle, and reads the fault registers only after that sequence has ended.

// File: rtl/tcm_ecc_pkg.sv
package tcm_ecc_pkg;

  localparam int CW_W = 12;
  typedef logic [CW_W-1:0] cw_t;

  localparam logic [1:0] CAUSE_CORR = 2'b01;
  localparam logic [1:0] CAUSE_UNC  = 2'b10;

  // control -> datapath strobes
  typedef struct packed {
    logic capReq;   // latch address and side of an accepted request
    logic wrEn;     // store enabled bytes of a write
    logic fixWr;    // write repaired codewords back, latch corrected data
    logic useFix;   // drive latched corrected data on the response
    logic faultCap; // offer the current fault to the fault registers
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic anyCorr;
    logic anyUnc;
    logic fetchQ;
  } dpStat_t;

  function automatic cw_t hamEncode(input logic [7:0] d);
    cw_t cw;
    int  k;
    logic par;
    cw = '0;
    k  = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p-1] = d[k];
        k++;
      end
    end
    for (int c = 0; c < 4; c++) begin
      par = 1'b0;
      for (int p = 1; p <= CW_W; p++) begin
        if (((p >> c) & 1) != 0) par = par ^ cw[p-1];
      end
      cw[(1 << c) - 1] = par;
    end
    return cw;
  endfunction

  function automatic logic [3:0] hamSyndrome(input cw_t cw);
    logic [3:0] s;
    s = '0;
    for (int p = 1; p <= CW_W; p++) begin
      if (cw[p-1]) s = s ^ 4'(p);
    end
    return s;
  endfunction

  function automatic logic [7:0] hamData(input cw_t cw);
    logic [7:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[k] = cw[p-1];
        k++;
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/tcm_ecc_dp.sv
module tcm_ecc_dp
  import tcm_ecc_pkg::*;
#(
  parameter int BYTES  = 4,
  parameter int ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  output dpStat_t               dpStat,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic                  reqFetch,
  input  logic [BYTES-1:0]      reqBe,
  input  logic [8*BYTES-1:0]    reqWdata,
  input  logic [CW_W*BYTES-1:0] injMask,
  input  logic                  faultClear,
  output logic [8*BYTES-1:0]    rspRdata,
  output logic [ADDR_W-1:0]     faultAddr,
  output logic [2:0]            faultStatus
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = 8 * BYTES;

  cw_t               mem [DEPTH][BYTES];
  logic [ADDR_W-1:0] addrQ;
  logic              fetchQ;
  logic [DATA_W-1:0] fixData;
  logic [DATA_W-1:0] corrData;
  cw_t               corrCw [BYTES];
  logic [BYTES-1:0]  byteCorr;
  logic [BYTES-1:0]  byteUnc;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    cw_t        rawCw;
    logic [3:0] syn;
    logic       inRange;
    assign rawCw   = mem[addrQ][b];
    assign syn     = hamSyndrome(rawCw);
    assign inRange = (syn != 4'd0) && (syn <= 4'(CW_W));
    assign byteCorr[b] = inRange;
    assign byteUnc[b]  = (syn > 4'(CW_W));
    assign corrCw[b]   = inRange ? (rawCw ^ (cw_t'(1) << (syn - 4'd1))) : rawCw;
    assign corrData[8*b +: 8] = hamData(corrCw[b]);
  end

  assign dpStat.anyCorr = |byteCorr;
  assign dpStat.anyUnc  = |byteUnc;
  assign dpStat.fetchQ  = fetchQ;

  assign rspRdata = strobe.useFix ? fixData : corrData;

  // array: user writes and repair write-back never share a cycle
  always_ff @(posedge clk) begin
    for (int b = 0; b < BYTES; b++) begin
      if (strobe.wrEn && reqBe[b])
        mem[reqAddr][b] <= hamEncode(reqWdata[8*b +: 8]) ^ injMask[CW_W*b +: CW_W];
      else if (strobe.fixWr)
        mem[addrQ][b] <= corrCw[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      fetchQ  <= 1'b0;
      fixData <= '0;
    end else begin
      if (strobe.capReq) begin
        addrQ  <= reqAddr;
        fetchQ <= reqFetch;
      end
      if (strobe.fixWr) fixData <= corrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultAddr   <= '0;
      faultStatus <= '0;
    end else if (faultClear) begin
      faultAddr   <= '0;
      faultStatus <= '0;
    end else if (strobe.faultCap && (faultStatus == 3'd0)) begin
      faultAddr   <= addrQ;
      faultStatus <= {fetchQ, dpStat.anyUnc ? CAUSE_UNC : CAUSE_CORR};
    end
  end

endmodule

// File: rtl/tcm_ecc_ctrl.sv
module tcm_ecc_ctrl
  import tcm_ecc_pkg::*;
#(
  parameter int ABORT_STALL = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  dpStat_t     dpStat,
  output ctrlStrobe_t strobe,
  output logic        reqReady,
  output logic        rspValid,
  output logic        prefetchAbort,
  output logic        dataAbort
);

  localparam int CNT_W = (ABORT_STALL < 2) ? 1 : $clog2(ABORT_STALL);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ABORT_STALL - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_FIXOUT, ST_HOLD, ST_ABORT
  } state_t;

  state_t           state, stateNxt;
  logic [CNT_W-1:0] holdCnt;

  always_comb begin
    stateNxt      = state;
    strobe        = '0;
    reqReady      = 1'b0;
    rspValid      = 1'b0;
    prefetchAbort = 1'b0;
    dataAbort     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady      = 1'b1;
        strobe.capReq = reqValid;
        strobe.wrEn   = reqValid && reqWrite;
        if (reqValid && !reqWrite) stateNxt = ST_CHECK;
      end
      ST_CHECK: begin
        if (dpStat.anyUnc) begin
          strobe.faultCap = 1'b1;
          if (dpStat.fetchQ) begin
            prefetchAbort = 1'b1;
            stateNxt      = ST_IDLE;
          end else begin
            stateNxt = ST_HOLD;
          end
        end else if (dpStat.anyCorr) begin
          strobe.faultCap = 1'b1;
          strobe.fixWr    = 1'b1;
          stateNxt        = ST_FIXOUT;
        end else begin
          rspValid = 1'b1;
          stateNxt = ST_IDLE;
        end
      end
      ST_FIXOUT: begin
        rspValid      = 1'b1;
        strobe.useFix = 1'b1;
        stateNxt      = ST_IDLE;
      end
      ST_HOLD: begin
        if (holdCnt == CNT_LAST) stateNxt = ST_ABORT;
      end
      ST_ABORT: begin
        dataAbort = 1'b1;
        stateNxt  = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      holdCnt <= '0;
    end else begin
      state <= stateNxt;
      if (state == ST_HOLD) holdCnt <= holdCnt + 1'b1;
      else                  holdCnt <= '0;
    end
  end

endmodule

// File: rtl/tcm_ecc.sv
module tcm_ecc
  import tcm_ecc_pkg::*;
#(
  parameter int BYTES       = 4,
  parameter int ADDR_W      = 6,
  parameter int ABORT_STALL = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic                  reqWrite,
  input  logic                  reqFetch,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [BYTES-1:0]      reqBe,
  input  logic [8*BYTES-1:0]    reqWdata,
  input  logic [12*BYTES-1:0]   injMask,
  output logic                  rspValid,
  output logic [8*BYTES-1:0]    rspRdata,
  output logic                  prefetchAbort,
  output logic                  dataAbort,
  input  logic                  faultClear,
  output logic [ADDR_W-1:0]     faultAddr,
  output logic [2:0]            faultStatus
);

  ctrlStrobe_t strobe;
  dpStat_t     dpStat;

  tcm_ecc_ctrl #(.ABORT_STALL(ABORT_STALL)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .dpStat(dpStat), .strobe(strobe), .reqReady(reqReady),
    .rspValid(rspValid), .prefetchAbort(prefetchAbort), .dataAbort(dataAbort)
  );

  tcm_ecc_dp #(.BYTES(BYTES), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dpStat(dpStat),
    .reqAddr(reqAddr), .reqFetch(reqFetch), .reqBe(reqBe),
    .reqWdata(reqWdata), .injMask(injMask), .faultClear(faultClear),
    .rspRdata(rspRdata), .faultAddr(faultAddr), .faultStatus(faultStatus)
  );

endmodule

// File: rtl/tcm_ecc_checker.sv
module tcm_ecc_checker #(
  parameter int ADDR_W      = 6,
  parameter int ABORT_STALL = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic              rspValid,
  input logic              prefetchAbort,
  input logic              dataAbort,
  input logic              faultClear,
  input logic [ADDR_W-1:0] faultAddr,
  input logic [2:0]        faultStatus
);

  // cycles since the last accepted read, counted while the port is busy
  logic [7:0] sinceAcc;
  always_ff @(posedge clk) begin
    if (!rstN)                                    sinceAcc <= '0;
    else if (reqValid && reqReady && !reqWrite)   sinceAcc <= 8'd1;
    else if (!reqReady && sinceAcc != 8'hff)      sinceAcc <= sinceAcc + 8'd1;
  end

  p_read_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=> !reqReady);

  p_rsp_timing_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (sinceAcc == 8'd1 || sinceAcc == 8'd2));

  p_abort_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    (prefetchAbort || dataAbort) |-> (!rspValid && !(prefetchAbort && dataAbort)));

  p_pabort_at_check_r4: assert property (@(posedge clk) disable iff (!rstN)
    prefetchAbort |-> sinceAcc == 8'd1);

  p_pabort_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    prefetchAbort |=> reqReady);

  p_dabort_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    dataAbort |-> (sinceAcc == 8'(ABORT_STALL + 2) && !reqReady));

  p_dabort_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    dataAbort |=> reqReady);

  p_fault_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
    (faultStatus != 3'd0 && !faultClear) |=> ($stable(faultStatus) && $stable(faultAddr)));

  p_fault_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    faultClear |=> (faultStatus == 3'd0 && faultAddr == '0));

endmodule

bind tcm_ecc tcm_ecc_checker #(.ADDR_W(ADDR_W), .ABORT_STALL(ABORT_STALL)) u_chk (.*);

// File: tb/tb_tcm_ecc.sv
module tb_tcm_ecc;

  localparam int BYTES  = 4;
  localparam int ADDR_W = 6;
  localparam int STALL  = 3;
  localparam int DEPTH  = 1 << ADDR_W;

  logic                clk = 1'b0;
  logic                rstN;
  logic                reqValid, reqWrite, reqFetch, faultClear;
  logic [ADDR_W-1:0]   reqAddr;
  logic [BYTES-1:0]    reqBe;
  logic [8*BYTES-1:0]  reqWdata;
  logic [12*BYTES-1:0] injMask;
  logic                reqReady, rspValid, prefetchAbort, dataAbort;
  logic [8*BYTES-1:0]  rspRdata;
  logic [ADDR_W-1:0]   faultAddr;
  logic [2:0]          faultStatus;

  always #4 clk = ~clk;

  tcm_ecc #(.BYTES(BYTES), .ADDR_W(ADDR_W), .ABORT_STALL(STALL)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqFetch(reqFetch), .reqAddr(reqAddr), .reqBe(reqBe),
    .reqWdata(reqWdata), .injMask(injMask), .rspValid(rspValid),
    .rspRdata(rspRdata), .prefetchAbort(prefetchAbort), .dataAbort(dataAbort),
    .faultClear(faultClear), .faultAddr(faultAddr), .faultStatus(faultStatus)
  );

  // reference model: stored data and stored corruption per byte
  logic [7:0]  dataM [DEPTH][BYTES];
  logic [11:0] maskM [DEPTH][BYTES];
  logic [2:0]  fStatM;
  int          fAddrM;
  int          nTests = 0;
  int          nFail  = 0;
  bit          done   = 1'b0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input int a, input logic [31:0] d, input logic [3:0] be,
                         input logic [47:0] inj, input string req);
    reqValid = 1'b1; reqWrite = 1'b1; reqFetch = 1'b0;
    reqAddr = ADDR_W'(a); reqWdata = d; reqBe = be; injMask = inj;
    check("R11", {req, " ready before write"}, reqReady, 1);
    @(negedge clk);
    reqValid = 1'b0; injMask = '0;
    check("R11", {req, " no response to write"}, rspValid, 0);
    for (int b = 0; b < BYTES; b++) begin
      if (be[b]) begin
        dataM[a][b] = d[8*b +: 8];
        maskM[a][b] = inj[12*b +: 12];
      end
    end
  endtask

  task automatic doRead(input int a, input bit fetch, input string req);
    logic [3:0]  syn;
    bit          unc, corr;
    logic [31:0] exp;
    int          n;
    bit          eRdy[8], eRsp[8], ePa[8], eDa[8];
    unc = 0; corr = 0;
    for (int b = 0; b < BYTES; b++) begin
      syn = 4'd0;
      for (int j = 0; j < 12; j++) if (maskM[a][b][j]) syn = syn ^ 4'(j + 1);
      if (syn > 4'd12) unc = 1;
      else if (syn != 4'd0) corr = 1;
      exp[8*b +: 8] = dataM[a][b];
    end
    for (int c = 0; c < 8; c++) begin
      eRdy[c] = 0; eRsp[c] = 0; ePa[c] = 0; eDa[c] = 0;
    end
    if (unc && fetch) begin
      n = 2; ePa[0] = 1; eRdy[1] = 1;
    end else if (unc) begin
      n = STALL + 3; eDa[STALL+1] = 1; eRdy[STALL+2] = 1;
    end else if (corr) begin
      n = 3; eRsp[1] = 1; eRdy[2] = 1;
    end else begin
      n = 2; eRsp[0] = 1; eRdy[1] = 1;
    end
    reqValid = 1'b1; reqWrite = 1'b0; reqFetch = fetch;
    reqAddr = ADDR_W'(a); reqBe = '0;
    check(req, "ready before read", reqReady, 1);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      reqValid = 1'b0;
      check(req, $sformatf("reqReady c%0d", c), reqReady, eRdy[c]);
      check(req, $sformatf("rspValid c%0d", c), rspValid, eRsp[c]);
      check(req, $sformatf("prefetchAbort c%0d", c), prefetchAbort, ePa[c]);
      check(req, $sformatf("dataAbort c%0d", c), dataAbort, eDa[c]);
      if (eRsp[c]) check(req, "rspRdata", rspRdata, exp);
    end
    if (corr && !unc)
      for (int b = 0; b < BYTES; b++) maskM[a][b] = '0;
    if ((corr || unc) && fStatM == 3'd0) begin
      fStatM = {fetch, unc ? 2'b10 : 2'b01};
      fAddrM = a;
    end
    check(req, "faultStatus", faultStatus, fStatM);
    check(req, "faultAddr", faultAddr, fAddrM);
  endtask

  task automatic doClear();
    faultClear = 1'b1;
    @(negedge clk);
    faultClear = 1'b0;
    fStatM = '0; fAddrM = 0;
    check("R8", "faultStatus after clear", faultStatus, 0);
    check("R8", "faultAddr after clear", faultAddr, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 0; reqWrite = 0; reqFetch = 0; faultClear = 0;
    reqAddr = '0; reqBe = '0; reqWdata = '0; injMask = '0;
    fStatM = '0; fAddrM = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10", "reqReady", reqReady, 1);
    check("R10", "rspValid", rspValid, 0);
    check("R10", "prefetchAbort", prefetchAbort, 0);
    check("R10", "dataAbort", dataAbort, 0);
    check("R10", "faultStatus", faultStatus, 0);

    // R1 / R11 clean writes and reads, both sides
    doWrite(0, 32'h1234_5678, 4'hF, '0, "R11");
    doWrite(1, 32'hA5A5_0FF0, 4'hF, '0, "R11");
    doWrite(63, 32'hFFFF_FFFF, 4'hF, '0, "R11");
    doWrite(2, 32'h0000_0000, 4'hF, '0, "R11");
    doRead(0, 0, "R1");
    doRead(1, 1, "R1");
    doRead(63, 0, "R1");
    doRead(2, 1, "R1");

    // R2 / R9 single-bit fault (byte 2, position 7) corrected with one stall
    doWrite(5, 32'hDEAD_BEEF, 4'hF, 48'(12'h040) << 24, "R9");
    doRead(5, 0, "R2");
    // R3 write-back: second read is clean
    doRead(5, 0, "R3");

    // R4 uncorrectable (positions 12 and 1, syndrome 13), instruction side; R7 keeps first
    doWrite(6, 32'hCAFE_F00D, 4'hF, 48'(12'h801), "R9");
    doRead(6, 1, "R4");
    check("R7", "first fault kept addr", faultAddr, 5);

    // R8 clear, then R5 data-side abort after the stall window
    doClear();
    doRead(6, 0, "R5");
    doClear();

    // R6 partial write leaves other bytes' codes, including a stored fault
    doWrite(7, 32'h1122_3344, 4'hF, 48'(12'h010) << 12, "R9");
    doWrite(7, 32'h0000_00AB, 4'h1, '0, "R6");
    doRead(7, 0, "R6");
    doClear();

    // R4 syndrome 14 (positions 12 and 2) in byte 3, fetch side
    doWrite(8, 32'h5566_7788, 4'hF, 48'(12'h802) << 36, "R9");
    doRead(8, 1, "R4");
    doClear();
    // R6 full rewrite replaces the faulty codeword
    doWrite(8, 32'h0BAD_C0DE, 4'hF, '0, "R6");
    doRead(8, 1, "R6");

    // R2 fault in a check bit (position 4), instruction side; R7 side bit
    doWrite(9, 32'h8000_0001, 4'hF, 48'(12'h008), "R9");
    doRead(9, 1, "R2");
    check("R7", "side bit", faultStatus[2], 1);
    doClear();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule